// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Mode

This block stores eight single-bit values and updates them one at a time: a 3-bit address picks which output receives the serial data bit. Two active-low controls, a clear and an enable, pick one of four modes:
- **Write**: the addressed bit is loaded on the clock edge.
- **Hold**: nothing changes.
- **Demultiplex**: the addressed output mirrors the data bit and all others read low.
- **Clear**: every output reads low.

The storage is made of edge-triggered registers with per-bit write strobes rather than transparent latches. The clear acts asynchronously.

The mode is a named state, decoded from the control pair {clr_n, en_n}. The states are:

| State | clr_n | en_n | Effect |
|---|---|---|---|
| MODE_DEMUX | 0 | 0 | addressed output mirrors data, others low |
| MODE_CLEAR | 0 | 1 | all outputs low |
| MODE_WRITE | 1 | 0 | addressed bit loaded on the edge |
| MODE_HOLD | 1 | 1 | nothing changes |

Every transition between these states is allowed, and each takes effect as soon as the controls change. Only MODE_WRITE waits for a rising clock edge.

A wider register is built from several instances. They share the data, the address, the clock and the clear, and each gets its own enable. Only one instance is enabled at a time, so only that instance stores.

Top module: `addr_latch_demux`

## Requirements
- R1: With clr_n=1 and en_n=0, the rising clock edge loads din into q[sel], and the new value is visible right after that edge.
- R2: During a write, every output other than q[sel] keeps its previous value.
- R3: With clr_n=1 and en_n=1, q stays unchanged across clock edges whatever din and sel do.
- R4: With clr_n=0 and en_n=0, q[sel] equals din without waiting for a clock edge, and every other output is 0.
- R5: With clr_n=0 and en_n=1, all outputs are 0, independent of din and sel.
- R6: Driving clr_n low zeroes the stored bits at once, without a clock edge. After demultiplexer mode, returning to hold mode shows all zeros.
- R7: sel is binary with bit 0 as the least significant bit: value k (0 to 7) addresses q[k].
- R8: Changing sel and din while en_n=1 writes nothing.
- R9: Two instances that share din, sel, clk and clr_n, each with its own enable, act as one 16-bit register: only the enabled instance changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock used for writes |
| clr_n | input | 1 | Asynchronous clear, active low |
| en_n | input | 1 | Enable, active low |
| din | input | 1 | Serial data bit |
| sel | input | ADDR_W (3) | Binary address of the target output |
| q | output | 2**ADDR_W (8) | The stored or demultiplexed bits |

## Verification
A write (R1, R2) lands on the first rising edge at which en_n is low, after one register stage. The bench therefore drives inputs on the falling edge and samples one time unit after the next rising edge.

Demultiplexer output and clear (R4, R5, R6) involve no clocked stage. The bench samples them one time unit after the inputs change, before any edge occurs. For the asynchronous clear it pulls clr_n low in the middle of a cycle to prove this.

Hold cases (R3, R8) are sampled after an edge has passed, to show that the edge had no effect.

// File: rtl/alatch_pkg.sv
package alatch_pkg;
    // Mode is the {clr_n, en_n} pair read as a two-bit value.
    typedef enum logic [1:0] {
        MODE_DEMUX = 2'b00,
        MODE_CLEAR = 2'b01,
        MODE_WRITE = 2'b10,
        MODE_HOLD  = 2'b11
    } mode_t;
endpackage

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
    import alatch_pkg::*;
(
    input  logic  clr_n,
    input  logic  en_n,
    output mode_t mode,
    output logic  wr_go
);
    always_comb begin
        mode  = mode_t'({clr_n, en_n});
        wr_go = 1'b0;
        unique case (mode)
            MODE_WRITE: wr_go = 1'b1;
            MODE_HOLD,
            MODE_DEMUX,
            MODE_CLEAR: wr_go = 1'b0;
        endcase
    end
endmodule

// File: rtl/alatch_sel_dec.sv
module alatch_sel_dec #(
    parameter  int ADDR_W  = 3,
    localparam int NUM_OUT = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0]  sel,
    output logic [NUM_OUT-1:0] hit
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_hit
        assign hit[i] = (sel == ADDR_W'(i));
    end
endmodule

// File: rtl/alatch_store.sv
module alatch_store #(
    parameter int NUM_OUT = 8
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic [NUM_OUT-1:0] wr_bits,
    input  logic               din,
    output logic [NUM_OUT-1:0] stored
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
        logic bit_r;
        // Asynchronous clear wins over any pending write.
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) begin
                bit_r <= 1'b0;
            end else if (wr_bits[i]) begin
                bit_r <= din;
            end
        end
        assign stored[i] = bit_r;
    end
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
    import alatch_pkg::*;
#(
    parameter  int ADDR_W  = 3,
    localparam int NUM_OUT = 1 << ADDR_W
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               en_n,
    input  logic               din,
    input  logic [ADDR_W-1:0]  sel,
    output logic [NUM_OUT-1:0] q
);
    mode_t              mode;
    logic               wr_go;
    logic [NUM_OUT-1:0] hit;
    logic [NUM_OUT-1:0] wr_bits;
    logic [NUM_OUT-1:0] stored;

    alatch_mode_dec u_mode (
        .clr_n (clr_n),
        .en_n  (en_n),
        .mode  (mode),
        .wr_go (wr_go)
    );

    alatch_sel_dec #(.ADDR_W(ADDR_W)) u_dec (
        .sel (sel),
        .hit (hit)
    );

    assign wr_bits = hit & {NUM_OUT{wr_go}};

    alatch_store #(.NUM_OUT(NUM_OUT)) u_store (
        .clk     (clk),
        .clr_n   (clr_n),
        .wr_bits (wr_bits),
        .din     (din),
        .stored  (stored)
    );

    // Output process: one arm per mode.
    always_comb begin
        unique case (mode)
            MODE_DEMUX: q = hit & {NUM_OUT{din}};
            MODE_CLEAR: q = '0;
            MODE_WRITE,
            MODE_HOLD:  q = stored;
        endcase
    end
endmodule

// File: rtl/alatch_chk.sv
module alatch_chk #(
    parameter  int ADDR_W  = 3,
    localparam int NUM_OUT = 1 << ADDR_W
) (
    input logic               clk,
    input logic               clr_n,
    input logic               en_n,
    input logic               din,
    input logic [ADDR_W-1:0]  sel,
    input logic [NUM_OUT-1:0] q
);
    // R1: an enabled edge stores din at the addressed position
    a_r1_write: assert property (@(posedge clk) disable iff (!clr_n)
        !en_n |=> (q[$past(sel)] == $past(din)));

    // R3: a disabled edge changes nothing
    a_r3_hold: assert property (@(posedge clk) disable iff (!clr_n)
        en_n |=> $stable(q));

    // R4, R5: modes with clear low, sampled mid-cycle state at the edge
    always @(posedge clk) begin
        if (clr_n === 1'b0 && en_n === 1'b1) begin
            a_r5_clear: assert (q == '0);
        end
        if (clr_n === 1'b0 && en_n === 1'b0) begin
            a_r4_demux_sel: assert (q[sel] == din);
            a_r4_demux_onehot: assert ($onehot0(q));
        end
    end
endmodule

bind addr_latch_demux alatch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .clr_n (clr_n),
    .en_n  (en_n),
    .din   (din),
    .sel   (sel),
    .q     (q)
);

// File: tb/addr_latch_demux_test.sv
module addr_latch_demux_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 12;

    // Vector layout: {clr_n, en_n, din, sel[2:0], tick, expected q[7:0]}
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b1, 3'd3, 1'b1, 8'h08},
        {1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 8'h09},
        {1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 8'h09},
        {1'b1, 1'b1, 1'b1, 3'd7, 1'b1, 8'h09},
        {1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 8'h01},
        {1'b1, 1'b0, 1'b1, 3'd7, 1'b1, 8'h81},
        {1'b0, 1'b1, 1'b1, 3'd5, 1'b0, 8'h00},
        {1'b0, 1'b0, 1'b1, 3'd5, 1'b0, 8'h20},
        {1'b0, 1'b0, 1'b0, 3'd5, 1'b0, 8'h00},
        {1'b0, 1'b0, 1'b1, 3'd6, 1'b1, 8'h40},
        {1'b1, 1'b1, 1'b1, 3'd6, 1'b1, 8'h00},
        {1'b1, 1'b0, 1'b1, 3'd6, 1'b1, 8'h40}
    };

    logic       clk = 1'b0;
    logic       clr_n, en_n, en_hi_n, din;
    logic [2:0] sel;
    logic [7:0] q, q_hi;
    logic [7:0] model;
    int         vectors = 0;
    int         miscompares = 0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    addr_latch_demux uut (
        .clk(clk), .clr_n(clr_n), .en_n(en_n), .din(din), .sel(sel), .q(q)
    );

    addr_latch_demux uut_hi (
        .clk(clk), .clr_n(clr_n), .en_n(en_hi_n), .din(din), .sel(sel), .q(q_hi)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic e, input logic d, input logic [2:0] s);
        @(negedge clk);
        clr_n = c; en_n = e; din = d; sel = s;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin
        clr_n = 1'b0; en_n = 1'b1; en_hi_n = 1'b1; din = 1'b0; sel = 3'd0;
        after_edge();
        after_edge();
        check("R5 reset state", q, 8'h00);
        check("R5 reset state hi", q_hi, 8'h00);

        // Table walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            automatic logic [14:0] v = VEC[i];
            drive(v[14], v[13], v[12], v[11:9]);
            if (v[8]) after_edge();
            else #1;
            check($sformatf("table %0d (R1 R2 R3 R4 R5 R6)", i), q, v[7:0]);
        end

        // R7 R1 R2: address sweep, writing ones then a pattern
        drive(1'b0, 1'b1, 1'b0, 3'd0);
        after_edge();
        model = 8'h00;
        for (int a = 0; a < 8; a++) begin
            drive(1'b1, 1'b0, 1'b1, 3'(a));
            after_edge();
            model[a] = 1'b1;
            check($sformatf("R7 R1 write one at %0d", a), q, model);
        end
        for (int a = 0; a < 8; a++) begin
            drive(1'b1, 1'b0, a[0], 3'(a));
            after_edge();
            model[a] = a[0];
            check($sformatf("R2 R1 pattern at %0d", a), q, model);
        end

        // R8: address and data move while enable is inactive
        for (int a = 0; a < 8; a++) begin
            drive(1'b1, 1'b1, ~a[0], 3'(7 - a));
            after_edge();
            check($sformatf("R8 disabled step %0d", a), q, model);
        end

        // R4 R7: demultiplexer sweep, no clock edge needed
        for (int a = 0; a < 8; a++) begin
            for (int d = 0; d < 2; d++) begin
                drive(1'b0, 1'b0, d[0], 3'(a));
                #1;
                check($sformatf("R4 R7 demux sel %0d din %0d", a, d), q,
                      d[0] ? (8'h01 << a) : 8'h00);
            end
        end
        drive(1'b1, 1'b1, 1'b1, 3'd2);
        after_edge();
        check("R6 hold after demux shows zero", q, 8'h00);

        // R6: asynchronous clear in the middle of a cycle
        drive(1'b1, 1'b0, 1'b1, 3'd4);
        after_edge();
        check("R1 write before async clear", q, 8'h10);
        #1;
        clr_n = 1'b0;
        en_n  = 1'b1;
        #1;
        check("R6 async clear before edge", q, 8'h00);
        after_edge();
        drive(1'b1, 1'b1, 1'b0, 3'd0);
        after_edge();
        check("R6 stored bits zero after clear", q, 8'h00);

        // R9: two instances as a 16-bit register
        drive(1'b1, 1'b0, 1'b1, 3'd1);
        after_edge();
        @(negedge clk);
        en_n = 1'b1; en_hi_n = 1'b0; din = 1'b1; sel = 3'd2;
        after_edge();
        check("R9 upper instance written", q_hi, 8'h04);
        check("R9 lower instance untouched", q, 8'h02);
        @(negedge clk);
        en_hi_n = 1'b1; en_n = 1'b0; din = 1'b1; sel = 3'd6;
        after_edge();
        check("R9 lower instance written", q, 8'h42);
        check("R9 upper instance untouched", q_hi, 8'h04);
        @(negedge clk);
        en_n = 1'b1;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule